// File: doc/BRIEF.md
# Complex Spectrum Wavelet Scaling Controller

This block runs one scaling pass of a frequency-domain wavelet transform. A complex signal spectrum sits in two source memories, one for the real parts and one for the imaginary parts. A single real wavelet spectrum is streamed in alongside it. For every point, the block multiplies the real part and the imaginary part by the same wavelet value, using two signed multipliers that work side by side. From each 32-bit product it keeps a 16-bit window and writes the two windows as a pair into a result memory. A later inverse transform stage reads that memory.

A pulse on the start input launches a pass. The block then drives the read addresses of both source memories and the write address and write enable of the result memory. It covers all points in ascending order, one per cycle. When the last pair has been written, it raises a one-cycle done pulse for the next controller in the chain. Both full-width products are also driven to monitor outputs, so the exact products can be observed while the truncated words are written.

Top module: `cplx_scale_ctrl`

## Requirements
- R1: After reset, and at any time until a start is accepted, `wr_en_o` and `done_o` are low.
- R2: An accepted start makes `rd_addr_re_o` and `rd_addr_im_o` carry the same address on every cycle. Starting on the cycle after the start is sampled, they step once per clock from 0 to 1023.
- R3: `res_re_o` equals bits [23:8] of the signed 32-bit product of the real sample and the wavelet sample. All values are 16-bit two's complement.
- R4: `res_im_o` equals bits [23:8] of the signed 32-bit product of the imaginary sample and the wavelet sample.
- R5: While `wr_en_o` is high, `mon_re_o` and `mon_im_o` carry the full 32-bit products of the pair being written.
- R6: The source memories have a read latency of one cycle, and the wavelet sample arrives with the same alignment. Each result is written one cycle after its address was issued, with `wr_addr_o` equal to that read address. `wr_en_o` is high for exactly 1024 consecutive cycles per pass, and addresses start at 0 and rise by 1 each cycle.
- R7: `done_o` is a single-cycle pulse. It comes on the cycle after the write to address 1023, which is 1026 cycles after the start was sampled.
- R8: A start that arrives while a pass is in progress (reading or writing) is ignored. The pass neither restarts nor gets longer, and no second pass follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a pass when idle |
| sig_re_i | input | 16 | Real-part read data |
| sig_im_i | input | 16 | Imaginary-part read data |
| wav_i | input | 16 | Wavelet sample, aligned with read data |
| rd_addr_re_o | output | 10 | Real-part source memory address |
| rd_addr_im_o | output | 10 | Imaginary-part source memory address |
| wr_addr_o | output | 10 | Result memory address |
| wr_en_o | output | 1 | Result memory write enable |
| res_re_o | output | 16 | Truncated real product |
| res_im_o | output | 16 | Truncated imaginary product |
| mon_re_o | output | 32 | Full real product |
| mon_im_o | output | 32 | Full imaginary product |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The hardest case to reach from the ports is a start that lands in the middle of a running pass. If the sequencer mishandled it, the index would be reset or the pass stretched, and in-range results would hide the fault. The bench raises start in the middle of a pass. It then checks that the write count, the address sequence and the time of done still match a pass that had no such start, and that nothing is written afterwards. Product extremes (-32768 squared, and 32767 times -32768) are driven through a dedicated data pattern so that the discarded high byte is exercised.

// File: rtl/cplx_scale_pkg.sv
package cplx_scale_pkg;
    localparam int SAMPLE_W = 16;
    localparam int NUM_PTS  = 1024;
    localparam int KEEP_LSB = 8;

    typedef enum logic {LANE_RE = 1'b0, LANE_IM = 1'b1} lane_e;
    localparam int NUM_LANES = 2;
endpackage

// File: rtl/trunc_mult.sv
module trunc_mult #(
    parameter int IN_W   = 16,
    parameter int LSB    = 8,
    localparam int PROD_W = 2 * IN_W
) (
    input  logic signed [IN_W-1:0]   a_i,
    input  logic signed [IN_W-1:0]   b_i,
    output logic signed [PROD_W-1:0] prod_o,
    output logic        [IN_W-1:0]   slice_o
);
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod    = a_i * b_i;
        prod_o  = prod;
        slice_o = prod[LSB+IN_W-1:LSB];
    end
endmodule

// File: rtl/pass_seq.sv
module pass_seq #(
    parameter int NPTS = 1024,
    localparam int AW  = $clog2(NPTS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          wr_en_o,
    output logic          done_o
);
    localparam logic [AW-1:0] LAST = AW'(NPTS - 1);

    typedef struct packed {
        logic          run;
        logic [AW-1:0] idx;
        logic          vld;
        logic [AW-1:0] waddr;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.vld   = s_q.run;
        s_d.waddr = s_q.idx;
        s_d.done  = s_q.vld && (s_q.waddr == LAST);
        if (s_q.run) begin
            s_d.idx = s_q.idx + 1'b1;
            if (s_q.idx == LAST) begin
                s_d.run = 1'b0;
                s_d.idx = '0;
            end
        end else if (start_i && !s_q.vld) begin
            s_d.run = 1'b1;
            s_d.idx = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rd_addr_o = s_q.idx;
    assign wr_addr_o = s_q.waddr;
    assign wr_en_o   = s_q.vld;
    assign done_o    = s_q.done;

    p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    p_done_after_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(wr_en_o) && $past(wr_addr_o) == LAST && !wr_en_o));
    p_addr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 1'b1));
    p_first_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_en_o) |-> (wr_addr_o == '0));
    p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.run && s_q.idx != LAST) |=> (s_q.run && s_q.idx == $past(s_q.idx) + 1'b1));
endmodule

// File: rtl/cplx_scale_ctrl.sv
module cplx_scale_ctrl
    import cplx_scale_pkg::*;
#(
    parameter int DW   = SAMPLE_W,
    parameter int NPTS = NUM_PTS,
    parameter int LSB  = KEEP_LSB,
    localparam int AW  = $clog2(NPTS),
    localparam int PW  = 2 * DW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [DW-1:0] sig_re_i,
    input  logic [DW-1:0] sig_im_i,
    input  logic [DW-1:0] wav_i,
    output logic [AW-1:0] rd_addr_re_o,
    output logic [AW-1:0] rd_addr_im_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          wr_en_o,
    output logic [DW-1:0] res_re_o,
    output logic [DW-1:0] res_im_o,
    output logic [PW-1:0] mon_re_o,
    output logic [PW-1:0] mon_im_o,
    output logic          done_o
);
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] lane_in  [NUM_LANES];
    logic [DW-1:0] lane_res [NUM_LANES];
    logic [PW-1:0] lane_mon [NUM_LANES];

    pass_seq #(.NPTS(NPTS)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .rd_addr_o (rd_addr),
        .wr_addr_o (wr_addr_o),
        .wr_en_o   (wr_en_o),
        .done_o    (done_o)
    );

    assign lane_in[LANE_RE] = sig_re_i;
    assign lane_in[LANE_IM] = sig_im_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        trunc_mult #(.IN_W(DW), .LSB(LSB)) u_mul (
            .a_i     (lane_in[g]),
            .b_i     (wav_i),
            .prod_o  (lane_mon[g]),
            .slice_o (lane_res[g])
        );
    end

    assign rd_addr_re_o = rd_addr;
    assign rd_addr_im_o = rd_addr;
    assign res_re_o     = lane_res[LANE_RE];
    assign res_im_o     = lane_res[LANE_IM];
    assign mon_re_o     = lane_mon[LANE_RE];
    assign mon_im_o     = lane_mon[LANE_IM];

    p_quiet_until_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_o && !done_o && !$past(wr_en_o)) |=> !done_o);
endmodule

// File: tb/tb_cplx_scale_ctrl.sv
module tb_cplx_scale_ctrl;
    localparam int N = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] sig_re = '0, sig_im = '0, wav = '0;
    logic [9:0]  rd_re, rd_im, wr_addr;
    logic        wr_en, done;
    logic [15:0] res_re, res_im;
    logic [31:0] mon_re, mon_im;

    int errors = 0;
    int checks = 0;
    int mode = 0;

    always #2 clk = ~clk;

    cplx_scale_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .sig_re_i(sig_re), .sig_im_i(sig_im), .wav_i(wav),
        .rd_addr_re_o(rd_re), .rd_addr_im_o(rd_im),
        .wr_addr_o(wr_addr), .wr_en_o(wr_en),
        .res_re_o(res_re), .res_im_o(res_im),
        .mon_re_o(mon_re), .mon_im_o(mon_im), .done_o(done)
    );

    function automatic logic [15:0] pick(int k, int which);
        int v;
        case (mode)
            0: begin
                if (which == 0)      v = k * 31 - 16000;
                else if (which == 1) v = 9000 - k * 17;
                else                 v = k * 13 - 6000;
            end
            1: begin
                int sel;
                sel = (which == 2) ? (k / 4) % 4 : (k + which) % 4;
                case (sel)
                    0: v = -32768;
                    1: v = 32767;
                    2: v = 0;
                    default: v = -1;
                endcase
            end
            default: v = (k * 40503 + which * 7919 + 4660) ^ (k << 5);
        endcase
        return v[15:0];
    endfunction

    // synchronous-read source memories, one cycle latency
    always_ff @(posedge clk) begin
        sig_re <= pick(int'(rd_re), 0);
        sig_im <= pick(int'(rd_im), 1);
        wav    <= pick(int'(rd_re), 2);
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_pass(input int m, input bit inject);
        logic signed [31:0] p_re, p_im;
        int writes = 0;
        int done_at = -1;
        int dones = 0;
        int bad_data = 0;
        int bad_addr = 0;
        int bad_rd = 0;
        mode = m;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int c = 1; c <= 1032; c++) begin
            if (c > 1) @(negedge clk);
            if (inject) start = (c == 500);
            if (rd_re != rd_im) bad_rd++;                                    // R2
            if (c >= 1 && c <= 1024 && int'(rd_re) != c - 1) bad_rd++;       // R2
            if (wr_en) begin
                int k;
                k = c - 2;
                writes++;
                if (int'(wr_addr) != k) bad_addr++;                          // R6
                p_re = $signed(pick(k, 0)) * $signed(pick(k, 2));
                p_im = $signed(pick(k, 1)) * $signed(pick(k, 2));
                if (res_re != p_re[23:8]) begin                             // R3
                    bad_data++;
                    if (bad_data < 4) $display("FAIL R3 k=%0d actual=%0h expected=%0h", k, res_re, p_re[23:8]);
                end
                if (res_im != p_im[23:8]) begin                             // R4
                    bad_data++;
                    if (bad_data < 4) $display("FAIL R4 k=%0d actual=%0h expected=%0h", k, res_im, p_im[23:8]);
                end
                if (mon_re != p_re || mon_im != p_im) begin                 // R5
                    bad_data++;
                    if (bad_data < 4) $display("FAIL R5 k=%0d actual=%0h expected=%0h", k, mon_re, p_re);
                end
            end
            if (done) begin
                dones++;
                if (done_at < 0) done_at = c;
            end
        end
        start = 1'b0;
        check(bad_data == 0, "R3/R4/R5 data mismatches", bad_data, 0);
        check(bad_rd == 0, "R2 read address sequence", bad_rd, 0);
        check(writes == N, "R6 write count", writes, N);
        check(bad_addr == 0, "R6 write address", bad_addr, 0);
        check(done_at == 1026, "R7 done timing", done_at, 1026);
        check(dones == 1, inject ? "R8 single done" : "R7 done width", dones, 1);
    endtask

    task automatic test_reset_idle();
        int seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wr_en || done) seen++;
        end
        check(seen == 0, "R1 idle outputs", seen, 0);
    endtask

    task automatic test_after_inject();
        int seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (wr_en || done) seen++;
        end
        check(seen == 0, "R8 no second pass", seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!wr_en && !done, "R1 reset state", {wr_en, done}, 0);
        rst_n = 1'b1;
        test_reset_idle();
        run_pass(0, 1'b0);
        run_pass(1, 1'b0);
        run_pass(2, 1'b0);
        run_pass(0, 1'b1);
        test_after_inject();
        run_pass(2, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule